// File: doc/BRIEF.md
# Receive Data Link Byte Buffer with Event Flags

This block sits between a serial data link receiver and a processor. The receiver hands over one byte per write strobe, along with a tag that marks the last byte of a frame. The byte and its tag go into a 64-entry first-in first-out store. The processor drains the store with a read strobe. The byte at the head and its tag are always visible on the read outputs, and the current occupancy is reported as a level.

Three sticky event flags report buffer conditions: full, near full and message waiting. Each flag is set on the rising edge of its source condition. It then stays set until the processor strobes a status read. Each flag passes through its own enable bit into a single interrupt line.

The meaning of the full flag depends on the framing mode. In framed (HDLC) mode it reports an overrun, which means the receiver tried to write into a store that was already full. In the two unformatted packing modes it reports that the level has reached a programmable message fill limit. In 6-bit packing mode only the low six data bits are kept.

Top module: `rx_dl_fifo`

## Requirements
- R1: After reset the level is 0, all three flags and the interrupt are 0, and the read data and tag read as 0.
- R2: Bytes and their end-of-frame tags come out in the order they were accepted. The head entry is shown on the read outputs, and an empty store shows data 0 with tag 0.
- R3: At each clock edge the level changes by the number of accepted writes minus the number of accepted reads. A write is accepted only when the level is below 64, and a read only when the level is above 0. The level never exceeds 64.
- R4: In framed mode (mode = 2'b00), a write strobe while the level is 64 is discarded and leaves the stored bytes and the level unchanged. The full flag is set at that same clock edge.
- R5: In the packing modes (mode = 2'b01 for 6-bit, 2'b10 or 2'b11 for 8-bit), the full flag is set at the clock edge after the level first becomes greater than or equal to the fill limit.
- R6: The near-full flag is set at the clock edge after the level first becomes greater than or equal to the near-full threshold.
- R7: The message flag is set at the clock edge after the store goes from holding no tagged byte to holding at least one.
- R8: A flag is set only on a rising edge of its source. If the flag is cleared while the condition still holds, it stays clear.
- R9: A status read strobe clears all three flags at the clock edge. If a new event arrives at the same edge, that flag ends up set.
- R10: The interrupt is high exactly when some flag is set and its enable bit is set. Enable bit 0 gates full, bit 1 gates near full, and bit 2 gates message.
- R11: In 6-bit packing mode the stored byte keeps data bits 5:0 and forces bits 7:6 to 0. In the other modes all eight bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 framed, 01 6-bit packing, 10/11 8-bit packing |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Received byte |
| wr_eom | input | 1 | Byte ends a complete or partial frame |
| rd_en | input | 1 | Processor read strobe; pops the head |
| rd_data | output | 8 | Head byte, 0 when empty |
| rd_eom | output | 1 | Head end-of-frame tag, 0 when empty |
| level | output | 7 | Number of stored bytes |
| near_thr | input | 7 | Near-full threshold |
| fill_lim | input | 7 | Message fill limit for packing modes |
| stat_rd | input | 1 | Status read strobe; clears flags |
| irq_en | input | 3 | Interrupt enables {message, near, full} |
| st_full | output | 1 | Full / overrun flag |
| st_near | output | 1 | Near-full flag |
| st_msg | output | 1 | Message-waiting flag |
| irq | output | 1 | Interrupt |

## Verification
An accepted write or read shows on the level and the head outputs right after the capturing edge. The overrun flag is set at that same edge. The near-full flag, the packing-mode full flag and the message flag each set one edge later, because their sources are computed from the registered level and the registered count of tagged bytes. The interrupt follows the flags without delay. The bench drives inputs on the falling edge and updates its queue model with the values present before the rising edge. It then compares every output on the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/rx_dl_fifo.sv
module rx_dl_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eom,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_eom,
  output logic [CW-1:0] level,
  input  logic [CW-1:0] near_thr,
  input  logic [CW-1:0] fill_lim,
  input  logic          stat_rd,
  input  logic [2:0]    irq_en,
  output logic          st_full,
  output logic          st_near,
  output logic          st_msg,
  output logic          irq
);

  localparam logic [1:0] M_HDLC = 2'b00;
  localparam logic [1:0] M_P6   = 2'b01;
  localparam logic [DW-1:0] P6_MASK = DW'({6{1'b1}});

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, eom_cnt;
  logic [2:0]    src, prev, flags;

  wire full_q  = (count == CW'(DEPTH));
  wire empty_q = (count == '0);
  wire wacc    = wr_en && !full_q;
  wire racc    = rd_en && !empty_q;
  wire hdlc    = (mode == M_HDLC);
  wire [DW:0] head = mem[rptr];
  wire [DW-1:0] wdat = (mode == M_P6) ? (wr_data & P6_MASK) : wr_data;

  assign src[0] = hdlc ? (wr_en && full_q) : (count >= fill_lim);
  assign src[1] = (count >= near_thr);
  assign src[2] = (eom_cnt != '0);

  always_ff @(posedge clk)
    if (wacc) mem[wptr] <= {wr_eom, wdat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      eom_cnt <= '0;
      prev    <= '0;
      flags   <= '0;
    end else begin
      if (wacc) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (racc) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      count   <= count + CW'(wacc) - CW'(racc);
      eom_cnt <= eom_cnt + CW'(wacc && wr_eom) - CW'(racc && head[DW]);
      prev    <= src;
      flags   <= (flags & ~{3{stat_rd}}) | (src & ~prev);
    end
  end

  assign rd_data = empty_q ? '0 : head[DW-1:0];
  assign rd_eom  = !empty_q && head[DW];
  assign level   = count;
  assign st_full = flags[0];
  assign st_near = flags[1];
  assign st_msg  = flags[2];
  assign irq     = |(flags & irq_en);

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R3
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && level == CW'(1)) |=> (level == '0));

  // R4
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HDLC && wr_en && level == CW'(DEPTH)) |=> st_full);

  // R4
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && level == CW'(DEPTH)) |=> (level == CW'(DEPTH)));

  // R7
  msg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eom && level == '0) |=> ##1 st_msg);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_full || st_near || st_msg));

endmodule

// File: tb/rx_dl_fifo_tb.sv
`timescale 1ns/1ps
module rx_dl_fifo_tb;
  localparam int DEPTH = 64;

  logic       clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b10;
  logic       wr_en = 0, wr_eom = 0, rd_en = 0, stat_rd = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] near_thr = 7'd4, fill_lim = 7'd10;
  logic [2:0] irq_en = 3'b000;
  logic [7:0] rd_data;
  logic       rd_eom, st_full, st_near, st_msg, irq;
  logic [6:0] level;

  int checks = 0, fails = 0;
  int q[$];
  bit [2:0] mflags = 0, mprev = 0;

  always #2 clk = ~clk;

  rx_dl_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eom(wr_eom), .rd_en(rd_en), .rd_data(rd_data), .rd_eom(rd_eom),
    .level(level), .near_thr(near_thr), .fill_lim(fill_lim), .stat_rd(stat_rd),
    .irq_en(irq_en), .st_full(st_full), .st_near(st_near), .st_msg(st_msg),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eoms();
    int n = 0;
    foreach (q[i]) if (q[i][8]) n++;
    return n;
  endfunction

  task automatic model_step();
    int sz = q.size();
    bit [2:0] s;
    bit wok;
    s[0] = (mode == 2'b00) ? (wr_en && sz == DEPTH) : (sz >= int'(fill_lim));
    s[1] = sz >= int'(near_thr);
    s[2] = eoms() > 0;
    mflags = (stat_rd ? 3'b000 : mflags) | (s & ~mprev);
    mprev = s;
    wok = wr_en && sz < DEPTH;
    if (rd_en && sz > 0) void'(q.pop_front());
    if (wok) q.push_back({23'd0, wr_eom, (mode == 2'b01) ? {2'b00, wr_data[5:0]} : wr_data});
  endtask

  task automatic compare();
    int hd = (q.size() > 0) ? q[0] : 0;
    chk("R3 level", int'(level), q.size());
    chk("R2 rd_data", int'(rd_data), hd & 8'hFF);
    chk("R2 rd_eom", int'(rd_eom), (hd >> 8) & 1);
    chk("R4/R5 st_full", int'(st_full), int'(mflags[0]));
    chk("R6 st_near", int'(st_near), int'(mflags[1]));
    chk("R7 st_msg", int'(st_msg), int'(mflags[2]));
    chk("R10 irq", int'(irq), int'(|(mflags & irq_en)));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = 0; rd_en = 0; stat_rd = 0; wr_eom = 0;
  endtask

  task automatic wr(input logic [7:0] d, input logic e);
    wr_en = 1; wr_data = d; wr_eom = e; cyc();
  endtask

  task automatic rd();
    rd_en = 1; cyc();
  endtask

  task automatic clr();
    stat_rd = 1; cyc();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 flags", int'({st_full, st_near, st_msg}), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    cyc();

    // 8-bit packing: order, near threshold
    for (int i = 1; i <= 5; i++) wr(8'hA0 + 8'(i), 1'b0);
    cyc();
    chk("R6 near set", int'(st_near), 1);
    clr();
    cyc();
    // R8: level still above threshold, flag stays clear
    chk("R8 near stays clear", int'(st_near), 0);
    rd(); rd();
    wr_en = 1; wr_data = 8'hB6; rd_en = 1; cyc();
    while (q.size() > 0) rd();
    rd();
    chk("R2 empty data", int'(rd_data), 0);

    // R11 6-bit packing masks upper bits
    mode = 2'b01;
    wr(8'hFF, 1'b0);
    chk("R11 masked byte", int'(rd_data), 8'h3F);
    rd();
    mode = 2'b10;
    wr(8'hC3, 1'b0);
    chk("R11 full byte", int'(rd_data), 8'hC3);
    rd();
    clr();

    // R5 fill limit in packing mode
    for (int i = 0; i < 10; i++) wr(8'(i), 1'b0);
    cyc();
    chk("R5 full at limit", int'(st_full), 1);
    while (q.size() > 0) rd();
    clr();
    cyc();

    // R4 framed-mode overrun
    mode = 2'b00;
    for (int i = 0; i < DEPTH; i++) wr(8'(i + 16), (i == 20));
    cyc();
    clr();
    cyc();
    wr_en = 1; wr_data = 8'hEE; stat_rd = 1; cyc();
    // R9 same-edge event survives status read
    chk("R9 event wins clear", int'(st_full), 1);
    chk("R4 level held", int'(level), DEPTH);
    chk("R4 head unchanged", int'(rd_data), 16);
    while (q.size() > 0) rd();
    clr();
    cyc();

    // R7 message flag and R10 enables
    wr(8'h5A, 1'b1);
    cyc();
    chk("R7 msg set", int'(st_msg), 1);
    irq_en = 3'b100; cyc();
    chk("R10 irq on msg", int'(irq), 1);
    irq_en = 3'b001; cyc();
    chk("R10 irq masked", int'(irq), 0);
    rd();
    clr();
    cyc();

    summary();
    $finish;
  end
endmodule